// File: doc/BRIEF.md
# Parameter Command Word Decoder

This block receives a word of five ASCII characters in parallel, together with a one-cycle qualifier. It accepts the word only when every character is a decimal digit. The leading character picks one of the user's stored parameters. The four characters after it form a decimal number. That number is turned into binary, clamped to the field's legal range, and written into the chosen register.

The registers hold six values: age, sex, body weight, aerobic capacity, daily calorie intake and target calorie deficit. They drive binary outputs for downstream arithmetic, and any one of them can be rewritten at any time. One reserved selector code returns every register to its preset value, which is the same state a synchronous reset gives. A one-cycle strobe marks each accepted update.

Top module: `param_cmd_decoder`

## Requirements
- R1: While `rst_n` is low at a rising edge, the registers load age 20, sex 0, weight 135, aerobic capacity 40, calories 2000 and deficit 100, and `loaded_o` goes low.
- R2: A word is taken only when each 7-bit character has bits [6:4] = 3'b011 and a low nibble of 9 or less. Any other word changes no register and raises no strobe.
- R3: The leading character, at bits [34:28], selects the target. 0 selects age, 1 sex, 2 weight, 3 aerobic capacity, 4 calories and 5 deficit. Only the selected register changes.
- R4: With payload characters at [27:21], [20:14], [13:7] and [6:0] holding digits d3, d2, d1 and d0, the stored value is d3*1000 + d2*100 + d1*10 + d0. Values up to 9999 are kept exactly for calories and deficit.
- R5: Values above a field's limit saturate: age to 126, weight to 510 and aerobic capacity to 254. Values at or below the limit are stored unchanged.
- R6: Selector 6 restores every register to the R1 preset values.
- R7: Selectors 7, 8 and 9 change no register and raise no strobe.
- R8: `loaded_o` is high for exactly the cycle after each accepted word with selector 0 to 6. It stays low when `word_vld_i` is low, even if the word holds digits. A word with `word_vld_i` held low changes nothing.
- R9: The sex flag is 1 when payload digit d0 is nonzero and 0 when d0 is zero.
- R10: When reset and a valid word arrive in the same cycle, reset wins. The result is the R1 state with `loaded_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; registers update on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| word_vld_i | input | 1 | One-cycle qualifier for `word_i` |
| word_i | input | 35 | Five 7-bit ASCII characters, selector in the top character |
| age_o | output | 7 | Stored age |
| sex_o | output | 1 | Stored sex flag |
| weight_o | output | 9 | Stored weight |
| aero_o | output | 8 | Stored aerobic capacity |
| kcal_o | output | 14 | Stored daily calorie intake |
| deficit_o | output | 14 | Stored target deficit |
| loaded_o | output | 1 | One-cycle strobe after an accepted update |

## Verification
Two functions can land in the same cycle: the synchronous reset and the loading of a qualified, all-digit word. The bench lowers `rst_n` and raises `word_vld_i` at the same falling edge, with an age command that would otherwise store a distinct value. After the next rising edge it expects the preset age and a low strobe. A second collision sends a preset command (selector 6) right after a normal load. That case is judged by the defaults it restores and the strobe it raises.

// File: rtl/pcd_pkg.sv
// Package: shared widths, character zone code and selector codes for the
// parameter command word decoder. Assumes 7-bit ASCII characters.
package pcd_pkg;
    localparam int CHAR_W = 7;
    localparam int NIB_W  = 4;
    localparam logic [2:0] DIGIT_ZONE = 3'b011;

    typedef enum logic [3:0] {
        SEL_AGE     = 4'd0,
        SEL_SEX     = 4'd1,
        SEL_WEIGHT  = 4'd2,
        SEL_AERO    = 4'd3,
        SEL_KCAL    = 4'd4,
        SEL_DEFICIT = 4'd5,
        SEL_PRESET  = 4'd6
    } sel_e;
endpackage

// File: rtl/pcd_char_check.sv
// Module: checks each character of the parallel word for being a decimal
// digit and extracts its numeric nibble. Assumes the selector sits in
// the most significant character. Purely combinational.
module pcd_char_check
    import pcd_pkg::*;
#(
    parameter int N_CHARS = 5
) (
    input  logic [N_CHARS*CHAR_W-1:0] word_i,
    output logic                      all_digits_o,
    output logic [N_CHARS*NIB_W-1:0]  digits_o
);
    logic [N_CHARS-1:0] is_digit;

    // One checker per character: zone bits and nibble range.
    for (genvar k = 0; k < N_CHARS; k++) begin : g_char
        logic [CHAR_W-1:0] ch;
        assign ch          = word_i[k*CHAR_W +: CHAR_W];
        assign is_digit[k] = (ch[6:4] == DIGIT_ZONE) && (ch[3:0] <= 4'd9);
        assign digits_o[k*NIB_W +: NIB_W] = ch[3:0];
    end

    // The word is valid only when every character is a digit.
    assign all_digits_o = &is_digit;
endmodule

// File: rtl/pcd_dec2bin.sv
// Module: converts N_DIG decimal digits (most significant first) into a
// binary value by repeated multiply-by-ten. Assumes the digits are 0..9
// and that VAL_W holds 10**N_DIG - 1.
module pcd_dec2bin
    import pcd_pkg::*;
#(
    parameter int N_DIG = 4,
    parameter int VAL_W = 14
) (
    input  logic [N_DIG*NIB_W-1:0] digits_i,
    output logic [VAL_W-1:0]       value_o
);
    // Horner accumulation across the digits.
    always_comb begin
        value_o = '0;
        for (int i = N_DIG - 1; i >= 0; i--) begin
            value_o = value_o * VAL_W'(10) + VAL_W'(digits_i[i*NIB_W +: NIB_W]);
        end
    end
endmodule

// File: rtl/pcd_field_regs.sv
// Module: holds the six user parameter registers, applies the selected
// update with range saturation, restores the presets on reset or on the
// preset selector, and emits a one-cycle strobe per accepted update.
// Assumes upd_i is already qualified by the valid pulse and digit check.
module pcd_field_regs
    import pcd_pkg::*;
#(
    parameter int VAL_W    = 14,
    parameter int AGE_W    = 7,
    parameter int WT_W     = 9,
    parameter int AERO_W   = 8,
    parameter int AGE_MAX  = 126,
    parameter int WT_MAX   = 510,
    parameter int AERO_MAX = 254,
    parameter int DEF_AGE  = 20,
    parameter int DEF_WT   = 135,
    parameter int DEF_AERO = 40,
    parameter int DEF_KCAL = 2000,
    parameter int DEF_DEFC = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_i,
    input  logic [NIB_W-1:0]  sel_i,
    input  logic [VAL_W-1:0]  value_i,
    input  logic [NIB_W-1:0]  sex_digit_i,
    output logic [AGE_W-1:0]  age_o,
    output logic              sex_o,
    output logic [WT_W-1:0]   weight_o,
    output logic [AERO_W-1:0] aero_o,
    output logic [VAL_W-1:0]  kcal_o,
    output logic [VAL_W-1:0]  deficit_o,
    output logic              loaded_o
);
    logic [AGE_W-1:0]  age_sat;
    logic [WT_W-1:0]   wt_sat;
    logic [AERO_W-1:0] aero_sat;

    // Clamp the payload to each bounded field's legal maximum.
    always_comb begin
        age_sat  = (value_i > VAL_W'(AGE_MAX))  ? AGE_W'(AGE_MAX)   : value_i[AGE_W-1:0];
        wt_sat   = (value_i > VAL_W'(WT_MAX))   ? WT_W'(WT_MAX)     : value_i[WT_W-1:0];
        aero_sat = (value_i > VAL_W'(AERO_MAX)) ? AERO_W'(AERO_MAX) : value_i[AERO_W-1:0];
    end

    // Register bank: reset/preset restore, selected load, strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_o     <= AGE_W'(DEF_AGE);
            sex_o     <= 1'b0;
            weight_o  <= WT_W'(DEF_WT);
            aero_o    <= AERO_W'(DEF_AERO);
            kcal_o    <= VAL_W'(DEF_KCAL);
            deficit_o <= VAL_W'(DEF_DEFC);
            loaded_o  <= 1'b0;
        end else begin
            loaded_o <= upd_i && (sel_i <= NIB_W'(SEL_PRESET));
            if (upd_i) begin
                case (sel_i)
                    SEL_AGE:     age_o     <= age_sat;
                    SEL_SEX:     sex_o     <= (sex_digit_i != '0);
                    SEL_WEIGHT:  weight_o  <= wt_sat;
                    SEL_AERO:    aero_o    <= aero_sat;
                    SEL_KCAL:    kcal_o    <= value_i;
                    SEL_DEFICIT: deficit_o <= value_i;
                    SEL_PRESET: begin
                        age_o     <= AGE_W'(DEF_AGE);
                        sex_o     <= 1'b0;
                        weight_o  <= WT_W'(DEF_WT);
                        aero_o    <= AERO_W'(DEF_AERO);
                        kcal_o    <= VAL_W'(DEF_KCAL);
                        deficit_o <= VAL_W'(DEF_DEFC);
                    end
                    default: ;
                endcase
            end
        end
    end

    // R1: first cycle out of reset shows presets and no strobe.
    a_r1_reset_presets: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (age_o == AGE_W'(DEF_AGE)) && !sex_o && (kcal_o == VAL_W'(DEF_KCAL)) && !loaded_o);

    // R2, R8: no qualified word means no change and no strobe.
    a_r2_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_i |=> !loaded_o && $stable(age_o) && $stable(sex_o) && $stable(weight_o)
                   && $stable(aero_o) && $stable(kcal_o) && $stable(deficit_o));

    // R5: bounded fields never exceed their limits.
    a_r5_field_limits: assert property (@(posedge clk) disable iff (!rst_n)
        (age_o <= AGE_W'(AGE_MAX)) && (weight_o <= WT_W'(WT_MAX)) && (aero_o <= AERO_W'(AERO_MAX)));

    // R6: preset selector restores the default values.
    a_r6_preset_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        upd_i && (sel_i == NIB_W'(SEL_PRESET)) |=> (weight_o == WT_W'(DEF_WT)) && (deficit_o == VAL_W'(DEF_DEFC)) && loaded_o);

    // R7: unused selectors leave everything untouched.
    a_r7_unused_sel: assert property (@(posedge clk) disable iff (!rst_n)
        upd_i && (sel_i > NIB_W'(SEL_PRESET)) |=> !loaded_o && $stable(age_o) && $stable(kcal_o) && $stable(deficit_o));

    // R8: a strobe is always caused by an accepted update one cycle before.
    a_r8_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
        loaded_o |-> $past(upd_i && (sel_i <= NIB_W'(SEL_PRESET))));
endmodule

// File: rtl/param_cmd_decoder.sv
// Module: top of the parameter command word decoder. Qualifies the word
// with the valid pulse and digit check, converts the four payload digits
// to binary and hands them to the register bank. Assumes the selector is
// the most significant character and that the valid pulse lasts one cycle.
module param_cmd_decoder
    import pcd_pkg::*;
#(
    parameter int N_CHARS  = 5,
    parameter int VAL_W    = 14,
    parameter int AGE_W    = 7,
    parameter int WT_W     = 9,
    parameter int AERO_W   = 8,
    parameter int AGE_MAX  = 126,
    parameter int WT_MAX   = 510,
    parameter int AERO_MAX = 254
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      word_vld_i,
    input  logic [N_CHARS*CHAR_W-1:0] word_i,
    output logic [AGE_W-1:0]          age_o,
    output logic                      sex_o,
    output logic [WT_W-1:0]           weight_o,
    output logic [AERO_W-1:0]         aero_o,
    output logic [VAL_W-1:0]          kcal_o,
    output logic [VAL_W-1:0]          deficit_o,
    output logic                      loaded_o
);
    localparam int N_PAY = N_CHARS - 1;

    logic                     all_digits;
    logic [N_CHARS*NIB_W-1:0] digits;
    logic [VAL_W-1:0]         payload;
    logic                     upd;
    logic [NIB_W-1:0]         sel;

    pcd_char_check #(.N_CHARS(N_CHARS)) u_check (
        .word_i       (word_i),
        .all_digits_o (all_digits),
        .digits_o     (digits)
    );

    pcd_dec2bin #(.N_DIG(N_PAY), .VAL_W(VAL_W)) u_conv (
        .digits_i (digits[N_PAY*NIB_W-1:0]),
        .value_o  (payload)
    );

    // Accept only a qualified word made entirely of digits.
    assign upd = word_vld_i && all_digits;
    assign sel = digits[N_CHARS*NIB_W-1 -: NIB_W];

    pcd_field_regs #(
        .VAL_W(VAL_W), .AGE_W(AGE_W), .WT_W(WT_W), .AERO_W(AERO_W),
        .AGE_MAX(AGE_MAX), .WT_MAX(WT_MAX), .AERO_MAX(AERO_MAX)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .upd_i       (upd),
        .sel_i       (sel),
        .value_i     (payload),
        .sex_digit_i (digits[NIB_W-1:0]),
        .age_o       (age_o),
        .sex_o       (sex_o),
        .weight_o    (weight_o),
        .aero_o      (aero_o),
        .kcal_o      (kcal_o),
        .deficit_o   (deficit_o),
        .loaded_o    (loaded_o)
    );
endmodule

// File: tb/sim_param_cmd_decoder.sv
module sim_param_cmd_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vld = 1'b0;
    logic [34:0] word = '0;
    logic [6:0]  age;
    logic        sex;
    logic [8:0]  weight;
    logic [7:0]  aero;
    logic [13:0] kcal, deficit;
    logic        loaded;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    int e_age, e_sex, e_wt, e_aero, e_kcal, e_def;

    always #4 clk = ~clk;

    param_cmd_decoder u0 (
        .clk(clk), .rst_n(rst_n), .word_vld_i(vld), .word_i(word),
        .age_o(age), .sex_o(sex), .weight_o(weight), .aero_o(aero),
        .kcal_o(kcal), .deficit_o(deficit), .loaded_o(loaded)
    );

    function automatic logic [34:0] mk(input int s, input int v);
        return {7'h30 + 7'(s), 7'h30 + 7'((v / 1000) % 10), 7'h30 + 7'((v / 100) % 10),
                7'h30 + 7'((v / 10) % 10), 7'h30 + 7'(v % 10)};
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic presets();
        e_age = 20; e_sex = 0; e_wt = 135; e_aero = 40; e_kcal = 2000; e_def = 100;
    endtask

    task automatic chk_all(input string req, input int exp_loaded);
        chk(req, "age", int'(age), e_age);
        chk(req, "sex", int'(sex), e_sex);
        chk(req, "weight", int'(weight), e_wt);
        chk(req, "aero", int'(aero), e_aero);
        chk(req, "kcal", int'(kcal), e_kcal);
        chk(req, "deficit", int'(deficit), e_def);
        chk(req, "loaded", int'(loaded), exp_loaded);
    endtask

    // Drive one qualified word; sample after the capturing edge.
    task automatic push(input logic [34:0] w);
        @(negedge clk); vld = 1'b1; word = w;
        @(negedge clk); vld = 1'b0;
    endtask

    task automatic t_reset();  // R1
        presets();
        chk_all("R1", 0);
    endtask

    task automatic t_loads();  // R3 R4 R8 R9
        push(mk(0, 45));   e_age = 45;    chk_all("R3", 1);
        push(mk(2, 300));  e_wt = 300;    chk_all("R3", 1);
        push(mk(3, 62));   e_aero = 62;   chk_all("R3", 1);
        push(mk(4, 9999)); e_kcal = 9999; chk_all("R4", 1);
        push(mk(5, 1234)); e_def = 1234;  chk_all("R4", 1);
        push(mk(1, 7));    e_sex = 1;     chk_all("R9", 1);
        push(mk(1, 10));   e_sex = 0;     chk_all("R9", 1);
        @(negedge clk); chk("R8", "loaded drop", int'(loaded), 0);
    endtask

    task automatic t_saturate();  // R5
        push(mk(0, 200));  e_age = 126;  chk("R5", "age sat", int'(age), e_age);
        push(mk(0, 127));  chk("R5", "age 127", int'(age), 126);
        push(mk(0, 126));  chk("R5", "age 126", int'(age), 126);
        push(mk(0, 125));  e_age = 125;  chk("R5", "age 125", int'(age), 125);
        push(mk(2, 9999)); e_wt = 510;   chk("R5", "weight sat", int'(weight), 510);
        push(mk(2, 509));  e_wt = 509;   chk("R5", "weight 509", int'(weight), 509);
        push(mk(3, 300));  e_aero = 254; chk("R5", "aero sat", int'(aero), 254);
        chk_all("R5", 1);
    endtask

    task automatic t_reject();  // R2
        logic [34:0] w;
        w = mk(0, 77); w[13:7] = 7'h3A;  push(w); chk_all("R2", 0);
        w = mk(4, 77); w[34:28] = 7'h41; push(w); chk_all("R2", 0);
        w = mk(5, 77); w[6:0] = 7'h20;   push(w); chk_all("R2", 0);
        w = mk(2, 77); w[27:21] = 7'h3F; push(w); chk_all("R2", 0);
    endtask

    task automatic t_unused();  // R7
        for (int s = 7; s <= 9; s++) begin
            push(mk(s, 33));
            chk_all("R7", 0);
        end
    endtask

    task automatic t_no_valid();  // R8
        @(negedge clk); vld = 1'b0; word = mk(0, 11);
        @(negedge clk); chk_all("R8", 0);
        @(negedge clk); word = '0;
    endtask

    task automatic t_back_to_back();  // R8 R6
        @(negedge clk); vld = 1'b1; word = mk(0, 50);
        @(negedge clk); word = mk(6, 0);
        e_age = 50; chk("R8", "first of pair", int'(age), 50);
        chk("R8", "strobe 1", int'(loaded), 1);
        @(negedge clk); vld = 1'b0;
        presets(); chk_all("R6", 1);
        @(negedge clk); chk("R8", "strobe end", int'(loaded), 0);
    endtask

    task automatic t_collide();  // R10
        push(mk(0, 99)); e_age = 99; chk("R10", "pre age", int'(age), 99);
        @(negedge clk); rst_n = 1'b0; vld = 1'b1; word = mk(0, 88);
        @(negedge clk); rst_n = 1'b1; vld = 1'b0;
        presets(); chk_all("R10", 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_loads();
        t_saturate();
        t_reject();
        t_unused();
        t_no_valid();
        t_back_to_back();
        t_collide();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule